// File: doc/BRIEF.md
# PS/2 Keyboard Receive Port

This block takes scan-code bytes sent by a PS/2 keyboard over its clock and data wires and offers them to a processor as two read-only I/O locations. The keyboard drives both wires. The block only listens, except that it pulls the clock wire low as flow control. A complete, well-formed byte is captured into a hold register, and a ready flag is raised. While the flag is up the keyboard clock is held low, so the keyboard cannot send another byte until software has taken the current one.

Both wire inputs are synchronized into the system clock domain. Bits are sampled on falling edges of the keyboard clock. A frame that stalls for longer than a set time is abandoned. The processor reads through a chip select, a read strobe and an address. Reading the byte location frees the flag and releases the clock wire. Reading the status location only reports state.

Top module: `kbd_rx_port`

## Requirements
- R1: After reset the ready flag is 0, the clock-hold output `ps2_clk_oe` is 0 (wire released) and `cpu_rdata` is 0.
- R2: A frame is 11 bits taken on successive falling edges of the keyboard clock: a start bit, 8 data bits LSB first, a parity bit, then a stop bit. It is accepted only when start is 0, stop is 1 and the 9 bits data+parity hold an odd number of ones. An accepted byte then reads back at address `DATA_ADDR` (default 0xF4), and bit 0 of address `STAT_ADDR` (default 0xF5) reads 1.
- R3: Bits 7 down to 1 of the status location equal bits 7 down to 1 of the held byte.
- R4: While the ready flag is 1, `ps2_clk_oe` is 1, which pulls the keyboard clock low.
- R5: A read cycle at `DATA_ADDR` while ready is 1 clears the ready flag and drops `ps2_clk_oe` on the following clock edge.
- R6: A frame with wrong parity leaves the ready flag at 0 and the clock released.
- R7: A frame whose start bit is 1, or whose stop bit is 0, is discarded the same way.
- R8: If no falling clock edge arrives for `TIMEOUT_US` microseconds in the middle of a frame, the partial frame is dropped. The next frame is then received from its start bit.
- R9: A read at `STAT_ADDR` leaves the ready flag, the held byte and `ps2_clk_oe` unchanged.
- R10: While ready is 1, clock falls are ignored and any partial frame is cleared. A frame forced through during that time changes nothing, and the next frame after release is received cleanly.
- R11: `cpu_rdata` is 0 unless `cpu_cs` and `cpu_rd` are both 1 and `cpu_addr` matches one of the two locations. It is combinational in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_i | input | 1 | Level sensed on the keyboard clock wire |
| ps2_data_i | input | 1 | Level sensed on the keyboard data wire |
| ps2_clk_oe | output | 1 | Open-drain enable: 1 drives the clock wire to 0, 0 leaves it floating |
| cpu_cs | input | 1 | Chip select for the read port |
| cpu_rd | input | 1 | Read strobe |
| cpu_addr | input | ADDR_W | I/O address |
| cpu_rdata | output | 8 | Read data |

## Verification
The bench keeps the default 125 MHz clock setting, two-stage synchronizer and default addresses. It shortens `TIMEOUT_US` to 8, so a stalled frame is abandoned after 1000 cycles. This puts the R8 abandonment of a partial frame within a short run, and it still leaves the 440-cycle frames of the bench's keyboard model well inside the window. The keyboard model can also be told to ignore the held-low clock, which is what exercises the R10 lockout.

// File: rtl/kbd_rx_pkg.sv
`timescale 1ns/1ps
package kbd_rx_pkg;

    // Bits arrive LSB first and are shifted in at the top, so the first
    // bit received ends up in the lowest field.
    typedef struct packed {
        logic       stop;
        logic       parity;
        logic [7:0] data;
        logic       start;
    } kbd_frame_t;

    localparam int FRAME_BITS = $bits(kbd_frame_t);

    typedef enum logic [1:0] {
        RD_NONE,
        RD_DATA,
        RD_STAT
    } kbd_rd_sel_e;

    typedef enum logic {
        RX_IDLE,
        RX_BITS
    } kbd_rx_state_e;

    function automatic logic frame_ok(input kbd_frame_t f);
        return (f.start == 1'b0) && (f.stop == 1'b1) && (^{f.parity, f.data});
    endfunction

    function automatic logic [7:0] status_word(input logic [7:0] d, input logic rdy);
        return {d[7:1], rdy};
    endfunction

endpackage

// File: rtl/kbd_line_sync.sv
`timescale 1ns/1ps
module kbd_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    // Lines idle high, so every stage resets to 1.
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '1;
                    else     stage_q[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '1;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/kbd_frame_rx.sv
`timescale 1ns/1ps
module kbd_frame_rx
    import kbd_rx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 125000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clk_lvl,
    input  logic       data_lvl,
    input  logic       inhibit,
    output logic       byte_valid,
    output logic [7:0] byte_out
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);

    kbd_rx_state_e          state_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [TO_W-1:0]        tmo_q;
    logic [FRAME_BITS-1:0]  shreg_q;
    logic [FRAME_BITS-1:0]  shift_nx;
    kbd_frame_t             frame_nx;
    logic                   prev_q;
    logic                   fall;

    assign fall     = prev_q & ~clk_lvl & ~inhibit;
    assign shift_nx = {data_lvl, shreg_q[FRAME_BITS-1:1]};
    assign frame_nx = kbd_frame_t'(shift_nx);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q     <= 1'b1;
            state_q    <= RX_IDLE;
            cnt_q      <= '0;
            tmo_q      <= '0;
            shreg_q    <= '0;
            byte_valid <= 1'b0;
            byte_out   <= '0;
        end else begin
            prev_q     <= clk_lvl;
            byte_valid <= 1'b0;
            if (inhibit) begin
                state_q <= RX_IDLE;
                cnt_q   <= '0;
                tmo_q   <= '0;
            end else begin
                case (state_q)
                    RX_IDLE: begin
                        tmo_q <= '0;
                        if (fall) begin
                            shreg_q <= shift_nx;
                            cnt_q   <= CNT_W'(1);
                            state_q <= RX_BITS;
                        end
                    end
                    RX_BITS: begin
                        if (fall) begin
                            tmo_q   <= '0;
                            shreg_q <= shift_nx;
                            if (cnt_q == CNT_W'(FRAME_BITS - 1)) begin
                                state_q <= RX_IDLE;
                                cnt_q   <= '0;
                                if (frame_ok(frame_nx)) begin
                                    byte_valid <= 1'b1;
                                    byte_out   <= frame_nx.data;
                                end
                            end else begin
                                cnt_q <= cnt_q + CNT_W'(1);
                            end
                        end else if (tmo_q == TO_W'(TIMEOUT_CYC - 1)) begin
                            state_q <= RX_IDLE;
                            cnt_q   <= '0;
                            tmo_q   <= '0;
                        end else begin
                            tmo_q <= tmo_q + TO_W'(1);
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/kbd_hold_reg.sv
`timescale 1ns/1ps
module kbd_hold_reg
    import kbd_rx_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 'hF4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 'hF5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [7:0]        byte_in,
    input  logic              cpu_cs,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [7:0]        cpu_rdata,
    output logic              ready,
    output logic [7:0]        hold_byte,
    output logic              clk_inhibit
);
    kbd_rd_sel_e sel;

    always_comb begin
        sel = RD_NONE;
        if (cpu_cs && cpu_rd) begin
            if (cpu_addr == DATA_ADDR)      sel = RD_DATA;
            else if (cpu_addr == STAT_ADDR) sel = RD_STAT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready     <= 1'b0;
            hold_byte <= '0;
        end else if (byte_valid && !ready) begin
            ready     <= 1'b1;
            hold_byte <= byte_in;
        end else if (sel == RD_DATA) begin
            ready <= 1'b0;
        end
    end

    always_comb begin
        case (sel)
            RD_DATA: cpu_rdata = hold_byte;
            RD_STAT: cpu_rdata = status_word(hold_byte, ready);
            default: cpu_rdata = '0;
        endcase
    end

    assign clk_inhibit = ready;

endmodule

// File: rtl/kbd_rx_port.sv
`timescale 1ns/1ps
module kbd_rx_port #(
    parameter int                CLK_KHZ     = 125000,
    parameter int                TIMEOUT_US  = 1000,
    parameter int                SYNC_STAGES = 2,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = 'hF4,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = 'hF5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ps2_clk_i,
    input  logic              ps2_data_i,
    output logic              ps2_clk_oe,
    input  logic              cpu_cs,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [7:0]        cpu_rdata
);
    localparam int TIMEOUT_CYC = (CLK_KHZ * TIMEOUT_US) / 1000;

    logic [1:0] line_s;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic       ready;
    logic [7:0] hold_byte;
    logic       inhibit;

    kbd_line_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ps2_data_i, ps2_clk_i}),
        .dout (line_s)
    );

    kbd_frame_rx #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_frame (
        .clk        (clk),
        .rst        (rst),
        .clk_lvl    (line_s[0]),
        .data_lvl   (line_s[1]),
        .inhibit    (inhibit),
        .byte_valid (rx_valid),
        .byte_out   (rx_byte)
    );

    kbd_hold_reg #(
        .ADDR_W    (ADDR_W),
        .DATA_ADDR (DATA_ADDR),
        .STAT_ADDR (STAT_ADDR)
    ) u_hold (
        .clk         (clk),
        .rst         (rst),
        .byte_valid  (rx_valid),
        .byte_in     (rx_byte),
        .cpu_cs      (cpu_cs),
        .cpu_rd      (cpu_rd),
        .cpu_addr    (cpu_addr),
        .cpu_rdata   (cpu_rdata),
        .ready       (ready),
        .hold_byte   (hold_byte),
        .clk_inhibit (inhibit)
    );

    assign ps2_clk_oe = inhibit;

endmodule

// File: rtl/kbd_rx_checker.sv
`timescale 1ns/1ps
module kbd_rx_checker #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 'hF4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 'hF5
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_cs,
    input logic              cpu_rd,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [7:0]        cpu_rdata,
    input logic              ps2_clk_oe,
    input logic              rx_valid,
    input logic [7:0]        rx_byte,
    input logic              ready,
    input logic [7:0]        hold_byte
);
    logic rd_data, rd_stat;
    assign rd_data = cpu_cs && cpu_rd && (cpu_addr == DATA_ADDR);
    assign rd_stat = cpu_cs && cpu_rd && (cpu_addr == STAT_ADDR);

    // R2: a fresh byte lands in the hold register and raises ready
    a_r2_accept: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !ready) |=> (ready && hold_byte == $past(rx_byte)));

    // R4: accepted byte pulls the keyboard clock low
    a_r4_inhibit: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !ready) |=> ps2_clk_oe);

    // R5: data read releases the clock
    a_r5_release: assert property (@(posedge clk) disable iff (rst)
        (ready && rd_data) |=> !ps2_clk_oe);

    // R9: status read keeps the hold state
    a_r9_status_keeps: assert property (@(posedge clk) disable iff (rst)
        (ready && rd_stat) |=> (ps2_clk_oe && $stable(hold_byte)));

    // R10: no byte completes while the clock is held
    a_r10_lockout: assert property (@(posedge clk) disable iff (rst)
        ps2_clk_oe |=> !rx_valid);

    // R3: status upper bits follow the held byte
    a_r3_mirror: assert property (@(posedge clk) disable iff (rst)
        rd_stat |-> (cpu_rdata[7:1] == hold_byte[7:1] && cpu_rdata[0] == ready));

    // R11: bus quiet when not addressed
    a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
        !(rd_data || rd_stat) |-> (cpu_rdata == 8'h00));

endmodule

bind kbd_rx_port kbd_rx_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_ADDR (DATA_ADDR),
    .STAT_ADDR (STAT_ADDR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_cs     (cpu_cs),
    .cpu_rd     (cpu_rd),
    .cpu_addr   (cpu_addr),
    .cpu_rdata  (cpu_rdata),
    .ps2_clk_oe (ps2_clk_oe),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .ready      (ready),
    .hold_byte  (hold_byte)
);

// File: tb/tb_kbd_rx_port.sv
`timescale 1ns/1ps
module tb_kbd_rx_port;

    localparam int HALF     = 20;
    localparam int TO_CYC   = 1000;
    localparam logic [7:0] A_DATA = 8'hF4;
    localparam logic [7:0] A_STAT = 8'hF5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       kb_clk = 1'b1;
    logic       kb_data = 1'b1;
    logic       force_through = 1'b0;
    logic       ps2_clk_i;
    logic       ps2_clk_oe;
    logic       cpu_cs = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_addr = 8'h00;
    logic [7:0] cpu_rdata;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    // open-drain wire: the port's enable pulls it low
    assign ps2_clk_i = kb_clk & (force_through | ~ps2_clk_oe);

    kbd_rx_port #(
        .CLK_KHZ    (125000),
        .TIMEOUT_US (8)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .ps2_clk_i  (ps2_clk_i),
        .ps2_data_i (kb_data),
        .ps2_clk_oe (ps2_clk_oe),
        .cpu_cs     (cpu_cs),
        .cpu_rd     (cpu_rd),
        .cpu_addr   (cpu_addr),
        .cpu_rdata  (cpu_rdata)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // kind: 0 good, 1 bad parity, 2 bad start, 3 bad stop
    function automatic logic [10:0] mk_frame(input logic [7:0] d, input int kind);
        logic par;
        par = ~^d;
        if (kind == 1) par = ~par;
        return {(kind == 3) ? 1'b0 : 1'b1, par, d, (kind == 2) ? 1'b1 : 1'b0};
    endfunction

    task automatic send_bits(input logic [10:0] f, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            kb_data = f[i];
            repeat (HALF) @(negedge clk);
            kb_clk = 1'b0;
            repeat (HALF) @(negedge clk);
            kb_clk = 1'b1;
        end
        kb_data = 1'b1;
    endtask

    // driver: pushes the byte it expects the port to deliver
    task automatic send_byte(input logic [7:0] d, input int kind);
        while (ps2_clk_oe && !force_through) @(negedge clk);
        if (kind == 0 && !force_through) exp_q.push_back(d);
        send_bits(mk_frame(d, kind), 11);
        repeat (10) @(negedge clk);
    endtask

    task automatic cpu_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_cs = 1'b1; cpu_rd = 1'b1; cpu_addr = a;
        #1;
        d = cpu_rdata;
        @(negedge clk);
        cpu_cs = 1'b0; cpu_rd = 1'b0; cpu_addr = 8'h00;
        #1;
    endtask

    // monitor: pops the next expected byte and compares what the port holds
    task automatic expect_pop();
        logic [7:0] st, dt, exp;
        if (exp_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL R2 actual=queue_empty expected=item");
            return;
        end
        exp = exp_q.pop_front();
        chk("R4 clock held while ready", {7'd0, ps2_clk_oe}, 8'd1);
        cpu_read(A_STAT, st);
        chk("R2 ready bit", {7'd0, st[0]}, 8'd1);
        chk("R3 status mirror", {st[7:1], 1'b0}, {exp[7:1], 1'b0});
        cpu_read(A_DATA, dt);
        chk("R2 data byte", dt, exp);
        chk("R5 clock released", {7'd0, ps2_clk_oe}, 8'd0);
        cpu_read(A_STAT, st);
        chk("R5 ready cleared", {7'd0, st[0]}, 8'd0);
    endtask

    task automatic expect_nothing(input string req);
        logic [7:0] st;
        cpu_read(A_STAT, st);
        chk(req, {7'd0, st[0]}, 8'd0);
        chk(req, {7'd0, ps2_clk_oe}, 8'd0);
    endtask

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk("R1 clock released", {7'd0, ps2_clk_oe}, 8'd0);
        chk("R1 rdata idle", cpu_rdata, 8'h00);
        cpu_read(A_STAT, v);
        chk("R1 ready clear", v, 8'h00);

        send_byte(8'hA5, 0);
        expect_pop();

        // R9: status reads leave everything intact
        send_byte(8'h3C, 0);
        cpu_read(A_STAT, v);
        cpu_read(A_STAT, v);
        chk("R9 ready kept", {7'd0, v[0]}, 8'd1);
        chk("R9 clock still held", {7'd0, ps2_clk_oe}, 8'd1);

        // R11: unaddressed accesses
        @(negedge clk);
        cpu_cs = 1'b1; cpu_rd = 1'b0; cpu_addr = A_DATA; #1;
        chk("R11 no strobe", cpu_rdata, 8'h00);
        cpu_rd = 1'b1; cpu_addr = 8'h10; #1;
        chk("R11 other address", cpu_rdata, 8'h00);
        cpu_cs = 1'b0; cpu_addr = A_DATA; #1;
        chk("R11 no select", cpu_rdata, 8'h00);
        @(negedge clk);
        cpu_rd = 1'b0; cpu_addr = 8'h00;
        chk("R11 ready survives stray access", {7'd0, ps2_clk_oe}, 8'd1);
        expect_pop();

        send_byte(8'h00, 0); expect_pop();
        send_byte(8'hFF, 0); expect_pop();
        send_byte(8'h80, 0); expect_pop();

        send_byte(8'h5A, 1); expect_nothing("R6 bad parity");
        send_byte(8'h42, 2); expect_nothing("R7 bad start");
        send_byte(8'h42, 3); expect_nothing("R7 bad stop");

        // R8: stalled partial frame, then a clean one
        send_bits(mk_frame(8'h99, 0), 4);
        repeat (TO_CYC + 100) @(negedge clk);
        send_byte(8'h77, 0);
        expect_pop();

        // R10: frame pushed through the held clock is ignored
        send_byte(8'h11, 0);
        force_through = 1'b1;
        send_byte(8'h22, 0);
        force_through = 1'b0;
        expect_pop();
        send_byte(8'h33, 0);
        expect_pop();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule